// File: doc/BRIEF.md
# Oscillator Trim Binary-Search Calibrator

This block finds an 8-bit trim code for an on-chip oscillator. It compares the oscillator against a precise external reference pulse and narrows the code by successive approximation. On a start request it sets the code to the middle of its range. It then repeats one step up to eight times. Each step waits one full reference period so the oscillator can settle after the code changes. It then counts the bus clocks that fall inside the next reference high pulse and divides that count by four. It compares the result with an expected value and moves the code by a step that halves every time.

A larger trim code slows the oscillator. A reading below the expected value means the clock runs slow, so the code is lowered. A reading above it means the clock runs fast, so the code is raised. An exact match ends the search at once. When the search ends, the final code is held on the output and a one-cycle store strobe tells the surrounding logic to write the code to non-volatile memory.

Top module: `osc_trim_search`

## Requirements
- R1: After reset, trim_o is 0x80, and busy_o, done_o and store_o are all 0.
- R2: A start_i sampled while busy_o is 0 makes busy_o 1, done_o 0 and trim_o 0x80 on the next cycle. The step index n is set to 1.
- R3: Each step first lets one reference rising edge pass without measuring, as settling time. It then measures the following high pulse. The measurement is the number of bus cycles for which the synchronized ref_i stays high. A pulse already in progress when start is accepted is never measured.
- R4: Let the scaled count be the measurement shifted right by 2. If the scaled count is below EXPECTED, trim_o is lowered by 128>>n. If it is above EXPECTED, trim_o is raised by 128>>n. The result is clamped to 0x00..0xFF, and n then increments.
- R5: If the scaled count equals EXPECTED, the search finishes immediately and trim_o keeps its value.
- R6: The search finishes after the measurement taken with n = 8. The step for that measurement is 0, so the code does not change.
- R7: On finishing, store_o is 1 for exactly one cycle. In that cycle trim_o holds the final code, busy_o is 0 and done_o is 1. done_o stays 1 until the next accepted start.
- R8: start_i has no effect while busy_o is 1: the trim sequence and the final code do not change.
- R9: The raw count saturates at 2^CNT_W-1 and never wraps. A very long pulse therefore reads as running fast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to start a calibration |
| ref_i | input | 1 | Asynchronous precision reference pulse |
| trim_o | output | TRIM_W | Current trim code |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished; final code valid |
| store_o | output | 1 | One-cycle request to store trim_o |

## Verification
A bench oscillator model makes each reference high pulse narrower as the trim code grows, so every code the search tries is answered by a real pulse width.

Each corner case below is paired with the failure it exposes:

- An early exact match must stop the search well before eight steps. A design that keeps going would emit extra code changes.
- A pulse too short to reach the target must walk the code down to 0x01.
- A saturating pulse must walk the code up to 0xFF. A wrapping counter would read that pulse as slow and walk the code down instead.
- The trim value is checked just after the settling pulse, before the measured pulse ends. A design that skips the settle step would change the code a full period early.
- A start pulse injected mid-search must be ignored. A design that restarts would reload 0x80 and break the expected sequence of codes.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic [1:0] {
    M_IDLE,
    M_SKIP,
    M_WAIT,
    M_COUNT
  } meter_state_e;
endpackage

// File: rtl/trim_ref_sync.sv
module trim_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/trim_pulse_meter.sv
module trim_pulse_meter
  import trim_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             level_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  meter_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_IDLE;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        M_IDLE:  if (arm_i) state_q <= M_SKIP;
        // settling period: let one rising edge pass
        M_SKIP:  if (rise_i) state_q <= M_WAIT;
        M_WAIT: begin
          if (rise_i) begin
            cnt_q   <= CNT_W'(1);
            state_q <= M_COUNT;
          end
        end
        M_COUNT: begin
          if (fall_i) begin
            valid_q <= 1'b1;
            state_q <= M_IDLE;
          end else if (level_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign valid_o = valid_q;
  assign count_o = cnt_q;

  a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_COUNT && level_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  a_r3_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/trim_search_fsm.sv
module trim_search_fsm #(
  parameter int TRIM_W   = 8,
  parameter int CMP_W    = 10,
  parameter int EXPECTED = 500,
  parameter int STEPS    = TRIM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              meas_valid_i,
  input  logic [CMP_W-1:0]  meas_scaled_i,
  output logic              arm_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              store_o
);
  localparam int                N_W   = $clog2(STEPS + 1) + 1;
  localparam logic [TRIM_W-1:0] MID_V = TRIM_W'(1) << (TRIM_W - 1);
  localparam logic [CMP_W-1:0]  EXP_V = CMP_W'(EXPECTED);
  localparam logic [N_W-1:0]    LAST  = N_W'(STEPS);

  logic [TRIM_W-1:0] trim_q, step, trim_next;
  logic [TRIM_W:0]   up_sum;
  logic [N_W-1:0]    n_q;
  logic              busy_q, done_q, store_q, arm_q;
  logic              too_slow, match;

  always_comb begin
    step     = MID_V >> n_q;
    too_slow = meas_scaled_i < EXP_V;
    match    = meas_scaled_i == EXP_V;
    up_sum   = {1'b0, trim_q} + {1'b0, step};
    if (too_slow)         trim_next = (trim_q < step) ? '0 : trim_q - step;
    else if (up_sum[TRIM_W]) trim_next = '1;
    else                  trim_next = up_sum[TRIM_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q  <= MID_V;
      n_q     <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      store_q <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      store_q <= 1'b0;
      arm_q   <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          trim_q <= MID_V;
          n_q    <= N_W'(1);
          busy_q <= 1'b1;
          done_q <= 1'b0;
          arm_q  <= 1'b1;
        end
      end else if (meas_valid_i) begin
        if (match || n_q == LAST) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          store_q <= 1'b1;
        end else begin
          n_q   <= n_q + N_W'(1);
          arm_q <= 1'b1;
        end
        if (!match) trim_q <= trim_next;
      end
    end
  end

  assign trim_o  = trim_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign store_o = store_q;
  assign arm_o   = arm_q;

  a_r2_load_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o && trim_o == MID_V));

  a_r7_store_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |=> !store_o);

  a_r7_store_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> (!busy_o && done_o));

  a_r8_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !meas_valid_i) |=> (busy_o && $stable(trim_o)));
endmodule

// File: rtl/osc_trim_search.sv
module osc_trim_search #(
  parameter int TRIM_W      = 8,
  parameter int CNT_W       = 12,
  parameter int SCALE_SHIFT = 2,
  parameter int EXPECTED    = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ref_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              store_o
);
  localparam int CMP_W = CNT_W - SCALE_SHIFT;

  logic             level, rise, fall, arm, meas_valid;
  logic [CNT_W-1:0] count;
  logic [CMP_W-1:0] scaled;

  trim_ref_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ref_i),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  trim_pulse_meter #(.CNT_W(CNT_W)) i_meter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .level_i (level),
    .rise_i  (rise),
    .fall_i  (fall),
    .valid_o (meas_valid),
    .count_o (count)
  );

  assign scaled = count[CNT_W-1:SCALE_SHIFT];

  trim_search_fsm #(
    .TRIM_W   (TRIM_W),
    .CMP_W    (CMP_W),
    .EXPECTED (EXPECTED)
  ) i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .meas_valid_i  (meas_valid),
    .meas_scaled_i (scaled),
    .arm_o         (arm),
    .trim_o        (trim_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .store_o       (store_o)
  );
endmodule

// File: tb/test_osc_trim_search.sv
module test_osc_trim_search;
  localparam int EXP    = 40;
  localparam int CNTW   = 10;
  localparam int LOW    = 20;
  localparam int SATMAX = (1 << CNTW) - 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       ref_i = 1'b0;
  logic [7:0] trim_o;
  logic       busy_o, done_o, store_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  int g_base = 260, g_slope = 1, g_fixed = 0;
  bit drv_en = 0;
  bit mon_en = 0;
  bit store_seen = 0;
  bit prev_store = 0;
  int store_cnt = 0;
  int exp_q[$];
  int exp_final;
  int last_trim;

  osc_trim_search #(.CNT_W(CNTW), .EXPECTED(EXP)) i_osc_trim_search (
    .clk_i, .rst_ni, .start_i, .ref_i, .trim_o, .busy_o, .done_o, .store_o
  );

  always #4 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // oscillator model: larger trim -> slower osc -> fewer bus clocks per pulse
  function automatic int width(input int t);
    int w;
    if (g_fixed > 0) return g_fixed;
    w = g_base - g_slope * t;
    if (w < 4) w = 4;
    return w;
  endfunction

  task automatic model_search();
    int t, w, s, st, nt;
    exp_q.delete();
    t = 128;
    for (int n = 1; n <= 8; n++) begin
      w = width(t);
      if (w > SATMAX) w = SATMAX;
      s = w / 4;
      if (s == EXP) break;
      st = 128 >> n;
      if (s < EXP) nt = (t - st < 0) ? 0 : t - st;
      else         nt = (t + st > 255) ? 255 : t + st;
      if (nt != t) exp_q.push_back(nt);
      t = nt;
    end
    exp_final = t;
  endtask

  initial begin
    int w;
    wait (drv_en);
    forever begin
      repeat (LOW) @(negedge clk_i);
      ref_i = 1'b1;
      w = width(int'(trim_o));
      repeat (w) @(negedge clk_i);
      ref_i = 1'b0;
    end
  end

  always @(negedge clk_i) begin
    cycles++;
    if (mon_en) begin
      if (prev_store) check(!store_o, "R7 store one cycle", int'(store_o), 0);
      prev_store = store_o;
      if (int'(trim_o) != last_trim) begin
        if (exp_q.size() == 0) check(0, "R3 R4 extra trim change", int'(trim_o), -1);
        else check(int'(trim_o) == exp_q[0], "R3 R4 trim sequence", int'(trim_o), exp_q[0]);
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        last_trim = int'(trim_o);
      end
      if (store_o) begin
        store_cnt++;
        store_seen = 1;
        check(int'(trim_o) == exp_final, "R5 R6 final trim at store", int'(trim_o), exp_final);
        check(!busy_o && done_o, "R7 flags at store", {busy_o, done_o}, 1);
      end
    end
  end

  initial begin
    #1;
    wait (cycles > 190000);
    check(0, "watchdog", cycles, 190000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic run(input int base, input int slope, input int fixed,
                     input bit timing_chk, input bit inject, input string tag);
    int to;
    g_base = base; g_slope = slope; g_fixed = fixed;
    model_search();
    store_seen = 0; store_cnt = 0; prev_store = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o && !done_o, {"R2 busy after start ", tag}, {busy_o, done_o}, 2);
    check(trim_o == 8'h80, {"R2 mid code ", tag}, int'(trim_o), 128);
    last_trim = int'(trim_o);
    mon_en = 1;
    if (timing_chk) begin
      drv_en = 1;
      // before the measured (second) pulse ends, trim must be untouched
      repeat (2 * LOW + 2 * width(128) - 2) @(negedge clk_i);
      check(trim_o == 8'h80, "R3 settle pulse not measured", int'(trim_o), 128);
    end
    if (inject) begin
      repeat (700) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      check(busy_o, "R8 start ignored while busy", int'(busy_o), 1);
    end
    to = 0;
    while (!store_seen && to < 40000) begin
      @(negedge clk_i);
      to++;
    end
    check(store_seen, {"R7 store issued ", tag}, int'(store_seen), 1);
    repeat (50) @(negedge clk_i);
    mon_en = 0;
    check(exp_q.size() == 0, {"R4 all steps seen ", tag}, exp_q.size(), 0);
    check(store_cnt == 1, {"R7 single store ", tag}, store_cnt, 1);
    check(done_o && !busy_o, {"R7 done held ", tag}, {busy_o, done_o}, 1);
    check(int'(trim_o) == exp_final, {"R5 R6 R8 final held ", tag}, int'(trim_o), exp_final);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(trim_o == 8'h80, "R1 reset trim", int'(trim_o), 128);
    check(!busy_o && !done_o && !store_o, "R1 reset flags",
          {busy_o, done_o, store_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    // R5: early exact match
    run(260, 1, 0, 1, 0, "match");
    check(exp_final == 100, "R5 model sanity", exp_final, 100);
    // R8: restart attempt in the middle of a search
    run(601, 3, 0, 0, 1, "inject");
    // R9: saturating pulse reads fast, code walks up to 0xFF
    run(0, 0, 1100, 0, 0, "sat");
    check(trim_o == 8'hFF, "R9 saturation to top", int'(trim_o), 255);
    // R6: too-slow pulse walks code down through all eight steps
    run(0, 0, 8, 0, 0, "slow");
    check(trim_o == 8'h01, "R6 eight steps down", int'(trim_o), 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule